// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Command Register

The block holds the main translation table of a memory management unit. Entries are arranged as sets by ways. Software reaches the table through a small register file:
- a tag word holding the virtual page, the present and global flags and the ASID;
- a frame word holding the physical frame and the permission bits;
- an index register;
- a PID register holding the current ASID;
- a command register.

Writing a code to the command register starts one operation. The operation is a probe, a slot allocation, a store with or without micro-TLB invalidation, a read-back, or a bare micro-TLB invalidation. The result appears in the index register or in the descriptor registers. A store that must also drop the micro-TLB copies raises a one-cycle flush pulse.

A combinational lookup port serves a downstream micro-TLB. It takes a virtual page number and returns the frame word of the unique matching entry, using the ASID held in the PID register.

Top module: `stlb_core`

## Requirements
- R1: After reset the tag, frame, index and PID registers read 0. busy_o is 0. Every entry is blank, so the lookup port misses everywhere.
- R2: A command occupies exactly one busy cycle. Its effects appear on the second rising edge after the command write. Any register write presented while busy_o is 1 is ignored, and that includes a further command. Command codes in wdata[2:0] are: 1 probe, 2 get-index, 3 write, 4 write without invalidate, 5 read, 6 micro invalidate. Codes 0 and 7 do nothing.
- R3: The linear index of an entry is set*WAYS+way. The set is tag bits [PAGE_SHIFT+SET_W-1:PAGE_SHIFT]. A probe with exactly one matching way loads that linear index into index bits [IDX_W-1:0] and clears flag bits 31 and 30.
- R4: A probe that matches no way sets the index register to 0x8000_0000 (bit 31 is the lookup error flag).
- R5: A probe that matches two or more ways sets the index register to 0xC000_0000 (bit 30 marks a duplicate).
- R6: An entry matches when its page bits [31:PAGE_SHIFT] are equal and its present bit (bit 10) is set. It also needs its ASID (bits [7:0]) to equal the probing ASID, unless its global bit (bit 8) is set, in which case any ASID matches.
- R7: Get-index picks the lowest-numbered way of the selected set whose present bit is clear. If every way is present, it picks the way named by a per-set round-robin pointer, which starts at 0 and advances on every such pick. Flags are cleared.
- R8: The write command stores the tag and frame registers into the entry at the current index. It also raises utlb_flush_o for exactly one cycle, in the cycle after execution.
- R9: Write without invalidate stores the entry and leaves utlb_flush_o low. The micro invalidate command pulses utlb_flush_o and leaves the table unchanged.
- R10: The read command loads the entry at the current index into the tag and frame registers.
- R11: An entry whose present bit is clear, such as one stored as two zero words, never matches a probe or a lookup.
- R12: The lookup port reports a hit only when exactly one way of the set matches the page and the PID ASID, and then returns that entry's frame word. No match or a duplicate match reports a miss with frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Write address: 0 tag, 1 frame, 2 index, 3 command, 4 PID |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 3 | Read address, same map; 3 returns busy in bit 0 |
| reg_rdata_o | output | 32 | Read data |
| busy_o | output | 1 | Command in progress |
| utlb_flush_o | output | 1 | One-cycle micro-TLB invalidate pulse |
| lk_vpn_i | input | 32-PAGE_SHIFT | Lookup virtual page number |
| lk_hit_o | output | 1 | Unique lookup match |
| lk_frame_o | output | 32 | Frame word of the matching entry |

## Verification
Two conditions are hard to reach from the ports. One is the duplicate-match case, which normal allocation never produces. The stimulus forces it by writing the index register directly and storing the same tag into two ways of one set. The other is the round-robin victim path, which needs every way of a set present. The bench fills both ways of one set and then issues repeated get-index commands, so the pointer is seen to step through the ways and wrap.

// File: rtl/stlb_pkg.sv
package stlb_pkg;
  localparam int DW           = 32;
  localparam int ASID_W       = 8;
  localparam int PRESENT_BIT  = 10;
  localparam int GLOBAL_BIT   = 8;
  localparam int ERR_BIT      = 31;
  localparam int DUP_BIT      = 30;

  localparam logic [2:0] RA_TAG   = 3'd0;
  localparam logic [2:0] RA_FRAME = 3'd1;
  localparam logic [2:0] RA_INDEX = 3'd2;
  localparam logic [2:0] RA_CMD   = 3'd3;
  localparam logic [2:0] RA_PID   = 3'd4;

  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_PROBE    = 3'd1,
    CMD_GETIDX   = 3'd2,
    CMD_WRITE    = 3'd3,
    CMD_WRITE_NI = 3'd4,
    CMD_READ     = 3'd5,
    CMD_UINV     = 3'd6,
    CMD_RSVD     = 3'd7
  } cmd_e;
endpackage

// File: rtl/stlb_way_match.sv
module stlb_way_match
  import stlb_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int VPN_W = 19,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][VPN_W-1:0]  vpn_i,
  input  logic [WAYS-1:0][ASID_W-1:0] asid_i,
  input  logic [WAYS-1:0]             present_i,
  input  logic [WAYS-1:0]             global_i,
  input  logic [VPN_W-1:0]            key_vpn_i,
  input  logic [ASID_W-1:0]           key_asid_i,
  output logic                        any_o,
  output logic                        dup_o,
  output logic [WAY_W-1:0]            way_o
);
  logic [WAYS-1:0] hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit[w] = present_i[w] && (vpn_i[w] == key_vpn_i) &&
                    (global_i[w] || (asid_i[w] == key_asid_i));
  end

  always_comb begin
    int cnt;
    cnt   = 0;
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit[w]) begin
        cnt++;
        way_o = WAY_W'(w);
      end
    end
    any_o = (cnt != 0);
    dup_o = (cnt > 1);
  end
endmodule

// File: rtl/stlb_victim_pick.sv
module stlb_victim_pick #(
  parameter int WAYS = 2,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  present_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             use_rr_o
);
  always_comb begin
    way_o    = rr_i;
    use_rr_o = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!present_i[w]) begin
        way_o    = WAY_W'(w);
        use_rr_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/stlb_core.sv
module stlb_core
  import stlb_pkg::*;
#(
  parameter int SETS       = 128,
  parameter int WAYS       = 2,
  parameter int PAGE_SHIFT = 13,
  localparam int VPN_W   = DW - PAGE_SHIFT,
  localparam int ENTRIES = SETS * WAYS,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  input  logic [2:0]       reg_raddr_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             busy_o,
  output logic             utlb_flush_o,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [DW-1:0]    lk_frame_o
);
  logic [DW-1:0]     tag_q, frm_q, idx_q;
  logic [ASID_W-1:0] pid_q;
  cmd_e              cmd_q;
  logic              busy_q, flush_q;
  logic [DW-1:0]     tag_mem [ENTRIES];
  logic [DW-1:0]     frm_mem [ENTRIES];
  logic [WAY_W-1:0]  rr_q    [SETS];

  logic [SET_W-1:0] pr_set, lk_set;
  logic [IDX_W-1:0] pr_base, lk_base, cur_idx;
  assign pr_set  = tag_q[PAGE_SHIFT +: SET_W];
  assign lk_set  = lk_vpn_i[SET_W-1:0];
  assign pr_base = IDX_W'(pr_set) * IDX_W'(WAYS);
  assign lk_base = IDX_W'(lk_set) * IDX_W'(WAYS);
  assign cur_idx = idx_q[IDX_W-1:0];

  logic [WAYS-1:0][VPN_W-1:0]  pr_vpn, lk_vpn;
  logic [WAYS-1:0][ASID_W-1:0] pr_asid, lk_asid;
  logic [WAYS-1:0]             pr_pres, pr_glob, lk_pres, lk_glob;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DW-1:0] pt, lt;
    assign pt         = tag_mem[pr_base + IDX_W'(w)];
    assign lt         = tag_mem[lk_base + IDX_W'(w)];
    assign pr_vpn[w]  = pt[DW-1:PAGE_SHIFT];
    assign pr_asid[w] = pt[ASID_W-1:0];
    assign pr_pres[w] = pt[PRESENT_BIT];
    assign pr_glob[w] = pt[GLOBAL_BIT];
    assign lk_vpn[w]  = lt[DW-1:PAGE_SHIFT];
    assign lk_asid[w] = lt[ASID_W-1:0];
    assign lk_pres[w] = lt[PRESENT_BIT];
    assign lk_glob[w] = lt[GLOBAL_BIT];
  end

  logic             pr_any, pr_dup, lk_any, lk_dup, vic_rr;
  logic [WAY_W-1:0] pr_way, lk_way, vic_way;

  stlb_way_match #(.WAYS(WAYS), .VPN_W(VPN_W)) u_probe_match (
    .vpn_i(pr_vpn), .asid_i(pr_asid), .present_i(pr_pres), .global_i(pr_glob),
    .key_vpn_i(tag_q[DW-1:PAGE_SHIFT]), .key_asid_i(tag_q[ASID_W-1:0]),
    .any_o(pr_any), .dup_o(pr_dup), .way_o(pr_way)
  );

  stlb_way_match #(.WAYS(WAYS), .VPN_W(VPN_W)) u_lookup_match (
    .vpn_i(lk_vpn), .asid_i(lk_asid), .present_i(lk_pres), .global_i(lk_glob),
    .key_vpn_i(lk_vpn_i), .key_asid_i(pid_q),
    .any_o(lk_any), .dup_o(lk_dup), .way_o(lk_way)
  );

  stlb_victim_pick #(.WAYS(WAYS)) u_victim (
    .present_i(pr_pres), .rr_i(rr_q[pr_set]),
    .way_o(vic_way), .use_rr_o(vic_rr)
  );

  logic [DW-1:0] idx_wr, probe_res, getidx_res;
  always_comb begin
    idx_wr                 = '0;
    idx_wr[ERR_BIT]        = reg_wdata_i[ERR_BIT];
    idx_wr[DUP_BIT]        = reg_wdata_i[DUP_BIT];
    idx_wr[IDX_W-1:0]      = reg_wdata_i[IDX_W-1:0];
    probe_res              = '0;
    if (pr_dup) begin
      probe_res[ERR_BIT]   = 1'b1;
      probe_res[DUP_BIT]   = 1'b1;
    end else if (!pr_any) begin
      probe_res[ERR_BIT]   = 1'b1;
    end else begin
      probe_res[IDX_W-1:0] = pr_base + IDX_W'(pr_way);
    end
    getidx_res             = '0;
    getidx_res[IDX_W-1:0]  = pr_base + IDX_W'(vic_way);
  end

  logic    cmd_ok;
  cmd_e    cmd_in;
  assign cmd_in = cmd_e'(reg_wdata_i[2:0]);
  assign cmd_ok = (cmd_in != CMD_NONE) && (cmd_in != CMD_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q   <= '0;
      frm_q   <= '0;
      idx_q   <= '0;
      pid_q   <= '0;
      cmd_q   <= CMD_NONE;
      busy_q  <= 1'b0;
      flush_q <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_mem[i] <= '0;
        frm_mem[i] <= '0;
      end
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      flush_q <= 1'b0;
      if (busy_q) begin
        busy_q <= 1'b0;
        unique case (cmd_q)
          CMD_PROBE:  idx_q <= probe_res;
          CMD_GETIDX: begin
            idx_q <= getidx_res;
            if (vic_rr) rr_q[pr_set] <= rr_q[pr_set] + 1'b1;
          end
          CMD_WRITE, CMD_WRITE_NI: begin
            tag_mem[cur_idx] <= tag_q;
            frm_mem[cur_idx] <= frm_q;
            flush_q          <= (cmd_q == CMD_WRITE);
          end
          CMD_READ: begin
            tag_q <= tag_mem[cur_idx];
            frm_q <= frm_mem[cur_idx];
          end
          CMD_UINV:   flush_q <= 1'b1;
          default:    ;
        endcase
      end else if (reg_we_i) begin
        unique case (reg_addr_i)
          RA_TAG:   tag_q <= reg_wdata_i;
          RA_FRAME: frm_q <= reg_wdata_i;
          RA_INDEX: idx_q <= idx_wr;
          RA_PID:   pid_q <= reg_wdata_i[ASID_W-1:0];
          RA_CMD: if (cmd_ok) begin
            cmd_q  <= cmd_in;
            busy_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (reg_raddr_i)
      RA_TAG:   reg_rdata_o = tag_q;
      RA_FRAME: reg_rdata_o = frm_q;
      RA_INDEX: reg_rdata_o = idx_q;
      RA_CMD:   reg_rdata_o = {{(DW-1){1'b0}}, busy_q};
      RA_PID:   reg_rdata_o = {{(DW-ASID_W){1'b0}}, pid_q};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign busy_o       = busy_q;
  assign utlb_flush_o = flush_q;
  assign lk_hit_o     = lk_any && !lk_dup;
  assign lk_frame_o   = lk_hit_o ? frm_mem[lk_base + IDX_W'(lk_way)] : '0;

  a_r2_busy_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !busy_q);

  a_r2_tag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmd_q != CMD_READ) |=> $stable(tag_q));

  a_r8_flush_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    utlb_flush_o |-> ($past(busy_q) &&
                      ($past(cmd_q) == CMD_WRITE || $past(cmd_q) == CMD_UINV)));

  a_r5_dup_has_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmd_q == CMD_PROBE) |=> (!idx_q[DUP_BIT] || idx_q[ERR_BIT]));

  a_r7_getidx_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmd_q == CMD_GETIDX) |=> (idx_q[ERR_BIT] == 1'b0 && idx_q[DUP_BIT] == 1'b0));
endmodule

// File: tb/stlb_core_tb_top.sv
module stlb_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PS = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  raddr = '0;
  logic [31:0] rdata;
  logic        busy, flush, lk_hit;
  logic [18:0] lk_vpn = '0;
  logic [31:0] lk_frame;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stlb_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(waddr),
    .reg_wdata_i(wdata), .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .busy_o(busy), .utlb_flush_o(flush), .lk_vpn_i(lk_vpn),
    .lk_hit_o(lk_hit), .lk_frame_o(lk_frame)
  );

  localparam logic [2:0] A_TAG = 0, A_FRM = 1, A_IDX = 2, A_CMD = 3, A_PID = 4;
  localparam logic [31:0] C_PROBE = 1, C_GETIDX = 2, C_WRITE = 3, C_WRNI = 4,
                          C_READ = 5, C_UINV = 6;

  localparam logic [31:0] VA_A  = 32'h0004_6000;  // set 35 -> idx 70,71
  localparam logic [31:0] TAG_A = 32'h0004_6412;
  localparam logic [31:0] TAG_B = 32'h0004_6421;
  localparam logic [31:0] FRM_A = 32'h0ABC_E02D;
  localparam logic [31:0] FRM_B = 32'h0123_4038;
  localparam logic [31:0] TAG_G = 32'h0010_2555;  // set 1 -> idx 2,3, global
  localparam logic [31:0] FRM_G = 32'h7770_0038;
  localparam logic [31:0] TAG_D = 32'h0000_4401;  // set 2 -> idx 4,5
  localparam logic [31:0] NF    = 32'h8000_0000;
  localparam logic [31:0] DUPV  = 32'hC000_0000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    raddr = a; #1; d = rdata;
  endtask

  // Issue a command; returns the flush level seen after execution.
  task automatic cmd(input logic [31:0] c, output logic fl);
    wreg(A_CMD, c);
    @(negedge clk);
    fl = flush;
  endtask

  task automatic lookup(input logic [31:0] va, output logic h, output logic [31:0] f);
    lk_vpn = va[31:PS]; #1; h = lk_hit; f = lk_frame;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic h;
    rreg(A_TAG, d);   chk("R1 tag", d, 0);
    rreg(A_FRM, d);   chk("R1 frame", d, 0);
    rreg(A_IDX, d);   chk("R1 index", d, 0);
    rreg(A_PID, d);   chk("R1 pid", d, 0);
    chk("R1 busy", {31'b0, busy}, 0);
    lookup(32'h0, h, d); chk("R1 lookup blank", {31'b0, h}, 0);
  endtask

  task automatic t_probe_write;
    logic [31:0] d; logic fl, h;
    wreg(A_TAG, TAG_A);
    cmd(C_PROBE, fl); rreg(A_IDX, d); chk("R4 probe miss", d, NF);
    chk("R11 blank no match", {31'b0, fl}, 0);
    cmd(C_GETIDX, fl); rreg(A_IDX, d); chk("R7 getidx empty set", d, 70);
    wreg(A_FRM, FRM_A);
    cmd(C_WRITE, fl); chk("R8 flush pulse", {31'b0, fl}, 1);
    @(negedge clk); chk("R8 flush one cycle", {31'b0, flush}, 0);
    cmd(C_PROBE, fl); rreg(A_IDX, d); chk("R3 probe hit index", d, 70);
    wreg(A_PID, 32'h12);
    lookup(VA_A, h, d); chk("R12 lookup hit", {31'b0, h}, 1); chk("R12 lookup frame", d, FRM_A);
    wreg(A_PID, 32'h13);
    lookup(VA_A, h, d); chk("R6 asid mismatch lookup", {31'b0, h}, 0);
    wreg(A_TAG, 32'h0004_6413);
    cmd(C_PROBE, fl); rreg(A_IDX, d); chk("R6 asid mismatch probe", d, NF);
  endtask

  task automatic t_victim;
    logic [31:0] d; logic fl;
    wreg(A_TAG, TAG_A);
    cmd(C_GETIDX, fl); rreg(A_IDX, d); chk("R7 first invalid way", d, 71);
    wreg(A_TAG, TAG_B); wreg(A_FRM, FRM_B);
    cmd(C_WRNI, fl); chk("R9 write_ni no flush", {31'b0, fl}, 0);
    cmd(C_PROBE, fl); rreg(A_IDX, d); chk("R9 write_ni stored", d, 71);
    cmd(C_GETIDX, fl); rreg(A_IDX, d); chk("R7 rr way0", d, 70);
    cmd(C_GETIDX, fl); rreg(A_IDX, d); chk("R7 rr way1", d, 71);
    cmd(C_GETIDX, fl); rreg(A_IDX, d); chk("R7 rr wrap", d, 70);
  endtask

  task automatic t_global;
    logic [31:0] d; logic fl, h;
    wreg(A_IDX, 2); wreg(A_TAG, TAG_G); wreg(A_FRM, FRM_G);
    cmd(C_WRITE, fl);
    wreg(A_PID, 32'h99);
    lookup(TAG_G, h, d); chk("R6 global lookup", d, FRM_G);
    wreg(A_TAG, 32'h0010_2477);
    cmd(C_PROBE, fl); rreg(A_IDX, d); chk("R6 global probe", d, 2);
  endtask

  task automatic t_dup;
    logic [31:0] d; logic fl, h;
    wreg(A_TAG, TAG_D); wreg(A_FRM, 32'h0000_2007);
    wreg(A_IDX, 4); cmd(C_WRNI, fl);
    wreg(A_IDX, 5); cmd(C_WRNI, fl);
    cmd(C_PROBE, fl); rreg(A_IDX, d); chk("R5 duplicate probe", d, DUPV);
    wreg(A_PID, 32'h01);
    lookup(TAG_D, h, d); chk("R12 duplicate lookup miss", {31'b0, h}, 0);
  endtask

  task automatic t_read_uinv;
    logic [31:0] d; logic fl;
    wreg(A_TAG, 0); wreg(A_FRM, 0);
    wreg(A_IDX, 71); cmd(C_READ, fl);
    rreg(A_TAG, d); chk("R10 read tag", d, TAG_B);
    rreg(A_FRM, d); chk("R10 read frame", d, FRM_B);
    cmd(C_UINV, fl); chk("R9 uinv flush", {31'b0, fl}, 1);
    cmd(C_PROBE, fl); rreg(A_IDX, d); chk("R9 uinv table intact", d, 71);
  endtask

  task automatic t_busy;
    logic [31:0] d; logic fl;
    wreg(A_TAG, TAG_A);
    wreg(A_CMD, C_PROBE);
    chk("R2 busy set", {31'b0, busy}, 1);
    we = 1'b1; waddr = A_TAG; wdata = 32'hDEAD_BEEF;
    @(negedge clk); we = 1'b0;
    chk("R2 busy one cycle", {31'b0, busy}, 0);
    rreg(A_TAG, d); chk("R2 write while busy ignored", d, TAG_A);
    rreg(A_IDX, d); chk("R2 command result", d, 70);
    wreg(A_CMD, C_PROBE);
    we = 1'b1; waddr = A_CMD; wdata = C_UINV;
    @(negedge clk); we = 1'b0;
    #1; chk("R2 command while busy ignored", {30'b0, busy, flush}, 0);
    @(negedge clk); chk("R2 no late flush", {31'b0, flush}, 0);
  endtask

  task automatic t_blank;
    logic [31:0] d; logic fl, h;
    wreg(A_IDX, 70); wreg(A_TAG, 0); wreg(A_FRM, 0);
    cmd(C_WRITE, fl);
    wreg(A_TAG, TAG_A);
    cmd(C_PROBE, fl); rreg(A_IDX, d); chk("R11 blanked probe miss", d, NF);
    wreg(A_PID, 32'h12);
    lookup(VA_A, h, d); chk("R11 blanked lookup miss", {31'b0, h}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_probe_write();
    t_victim();
    t_global();
    t_dup();
    t_read_uinv();
    t_busy();
    t_blank();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule